// File: doc/BRIEF.md
# DMA Read-Write Transfer Sequencer

This block carries out one DMA transfer for each start pulse. A transfer moves a single 8-bit or 16-bit unit. The block first runs a read phase, which fetches the unit into an internal holding register. It then runs a write phase, which stores that register at the destination. The two phases never overlap. The block decides at run time how many bus cycles each phase needs. It looks at three things:

- whether the address is odd,
- whether the external bus is in its 8-bit (narrow) setting,
- whether the accessed region needs a software wait.

The alignment and bus-width rules are applied to the source and the destination separately. The wait rule is applied to each bus cycle's own address.

The memory side is a request/ready bus on a 16-bit data path with two byte enables. Byte data travels on the lane selected by address bit 0: the low lane for even addresses, the high lane for odd ones. A wait region costs one extra clock per bus cycle, and the ready input is ignored during that clock. When the last write completes, the block raises a one-clock done pulse. It also presents the number of bus clocks the transfer consumed.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the block is idle, with busy, done and bus_req low and cyc_count zero. A start pulse is accepted only while idle. A start seen while busy has no effect on the transfer in progress.
- R2: Every bus cycle of the read phase (bus_we low) completes before the first write cycle (bus_we high). No read cycle follows a write within one transfer.
- R3: A 16-bit unit at an even address with the wide bus takes one bus cycle in that phase, with bus_be = 2'b11 on the even address.
- R4: A 16-bit unit at an odd address with the wide bus takes two byte cycles in that phase, at the address and at the address plus one. The byte at the odd address is the low byte of the unit. Source and destination are judged separately.
- R5: With narrow high, a 16-bit unit always takes two byte cycles per phase (low byte at the address, high byte at the address plus one). Every bus cycle then enables exactly one byte lane.
- R6: An 8-bit unit takes one bus cycle per phase whatever the alignment or bus width. bus_be is 2'b01 on an even address and 2'b10 on an odd one. The byte after the destination is left unchanged.
- R7: A bus cycle whose address lies in the special-register window (SFR_LO to SFR_HI), or in a top-address region whose bit is set in WAIT_MASK, lasts one extra clock. During that clock the request and address are held and ready is ignored.
- R8: While bus_rdy is low, the current bus cycle is held with the same address and direction, and every stalled clock adds one to cyc_count.
- R9: done is high for exactly one clock, the clock after the last write completes. At that point cyc_count equals the number of clocks bus_req was high since the start was accepted.
- R10: The bytes written to the destination equal the bytes read from the source, in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| size16 | input | 1 | 1: 16-bit unit, 0: 8-bit unit |
| narrow | input | 1 | 1: external bus in 8-bit setting |
| src_addr | input | AW | Source byte address |
| dst_addr | input | AW | Destination byte address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| cyc_count | output | CW | Bus clocks used by the current or last transfer |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1: write cycle, 0: read cycle |
| bus_addr | output | AW | Bus byte address |
| bus_be | output | 2 | Byte-lane enables |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Bus cycle may complete |

## Verification
Assertions check on every clock the local rules:
- the byte lane used on odd addresses,
- single-lane cycles in narrow mode,
- the request held through a wait clock or a ready stall,
- no read after a write,
- the single-clock done pulse,
- a busy start leaving the latched addresses alone.

The bench alone can show the run-time cycle totals, and that moved bytes land in the right order. It does this by sweeping unit size, bus width, source and destination parity, and source and destination region kinds. For each combination it compares done timing, cyc_count and memory contents with arithmetic expectations.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    // Byte-lane enable for a single byte at the given address parity
    function automatic logic [1:0] byte_lane(input logic odd);
        return odd ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dma_region_decode.sv
module dma_region_decode #(
    parameter int AW = 16,
    parameter int RB = 2,
    parameter logic [(1<<RB)-1:0] WAIT_MASK = '0,
    parameter logic [AW-1:0] SFR_LO = '0,
    parameter logic [AW-1:0] SFR_HI = '0
) (
    input  logic [AW-1:0] addr,
    output logic          wait_o
);
    localparam logic [AW-1:0] SFR_SPAN = SFR_HI - SFR_LO;

    logic [RB-1:0] region;
    logic [AW-1:0] sfr_off;

    always_comb begin
        region  = addr[AW-1 -: RB];
        sfr_off = addr - SFR_LO;
        wait_o  = WAIT_MASK[region] | (sfr_off <= SFR_SPAN);
    end
endmodule

// File: rtl/dma_phase_plan.sv
module dma_phase_plan #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic          sub,
    input  logic          size16,
    input  logic          narrow,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    be_o,
    output logic          last_o
);
    import dma_xfer_pkg::*;

    logic split;

    always_comb begin
        split  = size16 & (narrow | base[0]);
        addr_o = base + {{(AW-1){1'b0}}, sub & split};
        if (size16 && !split) be_o = 2'b11;
        else                  be_o = byte_lane(addr_o[0]);
        last_o = !split || sub;
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int RB = 2,
    parameter logic [(1<<RB)-1:0] WAIT_MASK = 4'b0100,
    parameter logic [AW-1:0] SFR_LO = 16'h0000,
    parameter logic [AW-1:0] SFR_HI = 16'h03FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          size16,
    input  logic          narrow,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cyc_count,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_be,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    input  logic          bus_rdy
);
    import dma_xfer_pkg::*;

    typedef struct packed {
        seq_st_e       st;
        logic          sub;
        logic          wdone;
        logic          done;
        logic          size16;
        logic          narrow;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [15:0]   hold;
        logic [CW-1:0] cnt;
    } seq_s;

    seq_s q, d;

    logic [AW-1:0] rd_addr, wr_addr;
    logic [1:0]    rd_be, wr_be;
    logic          rd_last, wr_last;
    logic          wt, last, rd_ph;
    logic [7:0]    rbyte, wbyte;

    dma_phase_plan #(.AW(AW)) u_rd_plan (
        .base(q.src), .sub(q.sub), .size16(q.size16), .narrow(q.narrow),
        .addr_o(rd_addr), .be_o(rd_be), .last_o(rd_last)
    );

    dma_phase_plan #(.AW(AW)) u_wr_plan (
        .base(q.dst), .sub(q.sub), .size16(q.size16), .narrow(q.narrow),
        .addr_o(wr_addr), .be_o(wr_be), .last_o(wr_last)
    );

    dma_region_decode #(
        .AW(AW), .RB(RB), .WAIT_MASK(WAIT_MASK), .SFR_LO(SFR_LO), .SFR_HI(SFR_HI)
    ) u_region (
        .addr(bus_addr), .wait_o(wt)
    );

    // Bus-side view of the current cycle
    always_comb begin
        rd_ph     = (q.st == ST_RD);
        bus_req   = (q.st != ST_IDLE);
        bus_we    = (q.st == ST_WR);
        bus_addr  = rd_ph ? rd_addr : wr_addr;
        bus_be    = rd_ph ? rd_be   : wr_be;
        last      = rd_ph ? rd_last : wr_last;
        rbyte     = bus_addr[0] ? bus_rdata[15:8] : bus_rdata[7:0];
        wbyte     = q.sub ? q.hold[15:8] : q.hold[7:0];
        bus_wdata = (bus_be == 2'b11) ? q.hold : {wbyte, wbyte};
        busy      = bus_req;
        done      = q.done;
        cyc_count = q.cnt;
    end

    // Next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_RD;
                    d.sub    = 1'b0;
                    d.wdone  = 1'b0;
                    d.size16 = size16;
                    d.narrow = narrow;
                    d.src    = src_addr;
                    d.dst    = dst_addr;
                    d.hold   = '0;
                    d.cnt    = '0;
                end
            end
            ST_RD, ST_WR: begin
                d.cnt = q.cnt + 1'b1;
                if (wt && !q.wdone) begin
                    d.wdone = 1'b1;
                end else if (bus_rdy) begin
                    d.wdone = 1'b0;
                    if (rd_ph) begin
                        if (bus_be == 2'b11) d.hold        = bus_rdata;
                        else if (q.sub)      d.hold[15:8]  = rbyte;
                        else                 d.hold[7:0]   = rbyte;
                    end
                    if (last) begin
                        d.sub = 1'b0;
                        if (rd_ph) begin
                            d.st = ST_WR;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.sub = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(q.src) && $stable(q.dst)); // R1
    AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |=> !(bus_req && !bus_we)); // R2
    AST_ODD_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_addr[0] |-> bus_be == 2'b10); // R6
    AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && q.narrow |-> $countones(bus_be) == 1); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && wt && !q.wdone |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_req && bus_we)); // R9

endmodule

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        size16 = 1'b0;
    logic        narrow = 1'b0;
    logic [15:0] src_addr = '0;
    logic [15:0] dst_addr = '0;
    logic        busy, done, bus_req, bus_we;
    logic [7:0]  cyc_count;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_be;
    logic        bus_rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [7:0] seed = 8'h21;

    logic [7:0] mem [0:4095];

    always #10 clk = ~clk;

    dma_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .size16(size16), .narrow(narrow),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done),
        .cyc_count(cyc_count), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    function automatic int idx(input logic [15:0] a);
        return int'({a[15:14], a[9:0]});
    endfunction

    always_comb bus_rdata = {mem[idx(bus_addr | 16'h1)], mem[idx(bus_addr & 16'hFFFE)]};

    always @(posedge clk) begin
        if (bus_req && bus_we && bus_rdy) begin
            if (bus_be[0]) mem[idx(bus_addr & 16'hFFFE)] <= bus_wdata[7:0];
            if (bus_be[1]) mem[idx(bus_addr | 16'h1)]    <= bus_wdata[15:8];
        end
    end

    // Wait rule from R7: SFR window 0x0000-0x03FF, region 2 (0x8000-0xBFFF) flagged
    function automatic int wcost(input logic [15:0] a);
        return (a <= 16'h03FF || a[15:14] == 2'd2) ? 2 : 1;
    endfunction

    function automatic int phase_cost(input logic s16, input logic nar, input logic [15:0] a);
        if (s16 && (nar || a[0])) return wcost(a) + wcost(a + 16'h1);
        return wcost(a);
    endfunction

    function automatic logic [15:0] region_base(input int r);
        if (r == 0) return 16'h4000;
        if (r == 1) return 16'h8000;
        return 16'h0100;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic s16, input logic nar, input logic [15:0] sa,
                       input logic [15:0] da, input int stall, input logic extra);
        logic [7:0] v0, v1;
        int exp_t, kd;
        logic seen_wr, bad_order;
        string tag;
        v0 = seed;
        v1 = seed ^ 8'h5A;
        seed = seed + 8'd7;
        @(negedge clk);
        mem[idx(sa)] <= v0;
        mem[idx(sa + 16'h1)] <= v1;
        mem[idx(da)] <= 8'hEE;
        mem[idx(da + 16'h1)] <= 8'hEE;
        @(negedge clk);
        exp_t = phase_cost(s16, nar, sa) + phase_cost(s16, nar, da) + stall;
        size16 = s16; narrow = nar; src_addr = sa; dst_addr = da; start = 1'b1;
        if (stall > 0) bus_rdy = 1'b0;
        kd = 0; seen_wr = 1'b0; bad_order = 1'b0;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (extra) begin
                    src_addr = 16'h4020;
                    chk(busy == 1'b1, "R1 busy", busy, 1);
                end else begin
                    start = 1'b0;
                end
            end
            if (k == 2) start = 1'b0;
            if (stall > 0 && k == stall + 1) bus_rdy = 1'b1;
            if (bus_req && bus_we) seen_wr = 1'b1;
            if (bus_req && !bus_we && seen_wr) bad_order = 1'b1;
            if (done) begin
                kd = k;
                break;
            end
        end
        if (!s16)                tag = "R6";
        else if (nar)            tag = "R5";
        else if (sa[0] || da[0]) tag = "R4";
        else                     tag = "R3";
        if (stall > 0) tag = "R8";
        if (exp_t != phase_cost(s16, nar, sa) + phase_cost(s16, nar, da) + stall) tag = "R7";
        chk(kd == exp_t + 1, {tag, " R9 done timing"}, kd, exp_t + 1);
        chk(int'(cyc_count) == exp_t, {tag, " R7 R9 cyc_count"}, cyc_count, exp_t);
        chk(!bad_order && seen_wr, "R2 phase order", bad_order, 0);
        @(negedge clk);
        chk(!done && !busy, "R9 done single / R1 idle", {done, busy}, 0);
        chk(mem[idx(da)] == v0, {tag, " R10 low byte"}, mem[idx(da)], v0);
        if (s16) chk(mem[idx(da + 16'h1)] == v1, {tag, " R10 high byte"}, mem[idx(da + 16'h1)], v1);
        else     chk(mem[idx(da + 16'h1)] == 8'hEE, "R6 next byte untouched", mem[idx(da + 16'h1)], 8'hEE);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req && cyc_count == 0, "R1 reset state",
            {busy, done, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req, "R1 idle after reset", busy, 0);
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 2; n++)
                for (int so = 0; so < 2; so++)
                    for (int dodd = 0; dodd < 2; dodd++)
                        for (int sr = 0; sr < 3; sr++)
                            for (int dr = 0; dr < 3; dr++)
                                run(s[0], n[0], region_base(sr) + 16'h10 + 16'(so),
                                    region_base(dr) + 16'h40 + 16'(dodd), 0, 1'b0);
        run(1'b1, 1'b0, 16'h4010, 16'h4040, 2, 1'b0);   // R8 stall
        run(1'b1, 1'b0, 16'h4011, 16'h8041, 3, 1'b0);   // R8 with R4 and R7
        run(1'b1, 1'b0, 16'h4010, 16'h4042, 0, 1'b1);   // R1 start while busy
        run(1'b0, 1'b1, 16'h0111, 16'h4043, 0, 1'b1);   // R1 with R6
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule